// File: doc/BRIEF.md
# Per-Cell Power-Up Stability Classifier

This block sorts memory cells by how consistently they powered up to the same value during an enrollment run. For each cell it receives the cell's address, how many of the reads returned '1', and how many reads were taken in total. From these it picks one of five classes: always '0', leaning '0', near the midpoint, leaning '1', or always '1'. Only the two "always" classes count as stable. Every other cell is flaky and must be kept out of key material.

The midpoint band scales with the read count. Its half-width is a rounded fraction of the total reads, set in parts per thousand. With the default setting and 1000 reads, the band covers counts 481 to 520.

The block also holds one mask bit per cell. When the caller streams enrollments taken at several temperatures, the mask is merged across them. A cell stays marked usable only while every pass has found it stable. A clear input returns the whole mask to "usable" before a new series of passes. Each result comes out two cycles after its input and carries the cell's merged mask bit.

Top module: `cell_stability_classifier`

## Requirements
- R1: The class code is 3 bits: 0 always-zero, 1 leaning-zero, 2 midpoint band, 3 leaning-one, 4 always-one. No other value appears. `outStable` is 1 exactly for codes 0 and 4.
- R2: A ones count of 0 gives code 0. This takes priority over every other rule, including a total of 0.
- R3: A non-zero ones count that is greater than or equal to the total gives code 4.
- R4: Let mid = floor(total/2) and d = floor((total*20 + 500)/1000), which is total times 2% rounded to nearest. A count that is not covered by R2 or R3, is above mid-d and is at most mid+d gives code 2. For total 1000, this is counts 481..520. For total 500 it is 241..260, and for total 37 it is 18..19.
- R5: A count from 1 up to and including mid-d, when not covered by R3, gives code 1.
- R6: A count above mid+d and below the total gives code 3.
- R7: Each input accepted with `inValid` high produces exactly one result with `outValid` high two clock edges later. That result carries the same address. Inputs may arrive on consecutive cycles, and results appear in input order.
- R8: `outMerged` equals the cell's stored mask bit ANDed with this result's stable bit. The stored bit then takes that value. Once a cell is flaky, it stays masked through later passes.
- R9: Reset, or one cycle of `clearMask`, sets every stored mask bit to 1. If a clear lands on the same edge as a mask update, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clearMask | input | 1 | Sets every stored mask bit to 1 (usable) |
| inValid | input | 1 | Input record present |
| inAddr | input | ADDR_W | Cell address |
| inOnes | input | CNT_W | Number of reads that returned '1' |
| inTotal | input | CNT_W | Total number of reads |
| outValid | output | 1 | Result present |
| outAddr | output | ADDR_W | Cell address of the result |
| outClass | output | 3 | Stability class code |
| outStable | output | 1 | Stable in this pass |
| outMerged | output | 1 | Usable across all passes since the last clear |

## Verification
At a total of 1000 reads, the classifier is tried with the counts on both sides of every boundary: 0, 1, 480, 481, 500, 520, 521, 999 and 1000, plus a count above the total. This separates an off-by-one in each comparison from a wrong priority between the rules.

It is also tried with totals of 500, 37 and 0. These show whether the band really scales with the read count and whether it rounds. The total of 0 checks that the all-zero rule takes precedence.

Merge sequences repeat one address across stable, flaky and stable passes. They show the mask is sticky rather than last-value. A clear issued in the same cycle as an update shows which of the two wins. A back-to-back burst to a single address separates correct write-then-read ordering from a stale mask read.

// File: rtl/cell_class_pkg.sv
package cell_class_pkg;

  typedef enum logic [2:0] {
    CLS_ALWAYS0 = 3'd0,
    CLS_LEAN0   = 3'd1,
    CLS_MIDBAND = 3'd2,
    CLS_LEAN1   = 3'd3,
    CLS_ALWAYS1 = 3'd4
  } cellClass_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadA;     // capture new record into stage A
    logic loadB;     // classify stage A and update mask
    logic clearAll;  // set every mask bit to usable
  } ctrlStrobe_t;

endpackage

// File: rtl/band_limits.sv
module band_limits #(
  parameter int CNT_W         = 11,
  parameter int HALF_PERMILLE = 20
) (
  input  logic [CNT_W-1:0] totalIn,
  output logic [CNT_W-1:0] loExcl,   // band starts above this
  output logic [CNT_W:0]   hiIncl    // band ends at this (inclusive)
);
  localparam int PROD_W = CNT_W + 12;
  localparam logic [PROD_W-1:0] SCALE = PROD_W'(HALF_PERMILLE);
  localparam logic [PROD_W-1:0] HALFK = PROD_W'(500);
  localparam logic [PROD_W-1:0] ONEK  = PROD_W'(1000);

  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] quot;
  logic [CNT_W-1:0]  delta;
  logic [CNT_W-1:0]  mid;

  always_comb begin
    prod  = PROD_W'(totalIn) * SCALE + HALFK;
    quot  = prod / ONEK;
    delta = quot[CNT_W-1:0];
    mid   = totalIn >> 1;
    loExcl = (delta > mid) ? '0 : (mid - delta);
    hiIncl = {1'b0, mid} + {1'b0, delta};
  end

endmodule

// File: rtl/classifier_ctrl.sv
module classifier_ctrl
  import cell_class_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        clearMask,
  output ctrlStrobe_t strobe,
  output logic        outValid
);
  logic validA;
  logic validB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validA <= 1'b0;
      validB <= 1'b0;
    end else begin
      validA <= inValid;
      validB <= validA;
    end
  end

  always_comb begin
    strobe.loadA    = inValid;
    strobe.loadB    = validA;
    strobe.clearAll = clearMask;
  end

  assign outValid = validB;

  AST_ONE_OUT_PER_IN: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid, 2)); // R7
  AST_NO_DROP: assert property (@(posedge clk) disable iff (!rstN)
    $past(inValid, 2) && $past(rstN, 2) |-> outValid); // R7

endmodule

// File: rtl/classifier_dp.sv
module classifier_dp
  import cell_class_pkg::*;
#(
  parameter int ADDR_W        = 8,
  parameter int CNT_W         = 11,
  parameter int HALF_PERMILLE = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [CNT_W-1:0]  inOnes,
  input  logic [CNT_W-1:0]  inTotal,
  output logic [ADDR_W-1:0] outAddr,
  output logic [2:0]        outClass,
  output logic              outStable,
  output logic              outMerged
);
  localparam int NUM_CELLS = 1 << ADDR_W;

  logic [CNT_W-1:0]  limLo;
  logic [CNT_W:0]    limHi;

  logic [ADDR_W-1:0] aAddr;
  logic [CNT_W-1:0]  aOnes;
  logic [CNT_W-1:0]  aTotal;
  logic [CNT_W-1:0]  aLo;
  logic [CNT_W:0]    aHi;

  cellClass_t        clsNext;
  logic              stableNext;
  logic              mergedNext;
  logic [NUM_CELLS-1:0] maskBits;

  band_limits #(.CNT_W(CNT_W), .HALF_PERMILLE(HALF_PERMILLE)) uLimits (
    .totalIn(inTotal),
    .loExcl (limLo),
    .hiIncl (limHi)
  );

  // stage A: capture record and its band limits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aAddr  <= '0;
      aOnes  <= '0;
      aTotal <= '0;
      aLo    <= '0;
      aHi    <= '0;
    end else if (strobe.loadA) begin
      aAddr  <= inAddr;
      aOnes  <= inOnes;
      aTotal <= inTotal;
      aLo    <= limLo;
      aHi    <= limHi;
    end
  end

  // class decision, priority: zero count, full count, band, below, above
  always_comb begin
    if (aOnes == '0)
      clsNext = CLS_ALWAYS0;
    else if (aOnes >= aTotal)
      clsNext = CLS_ALWAYS1;
    else if ((aOnes > aLo) && ({1'b0, aOnes} <= aHi))
      clsNext = CLS_MIDBAND;
    else if (aOnes <= aLo)
      clsNext = CLS_LEAN0;
    else
      clsNext = CLS_LEAN1;
    stableNext = (clsNext == CLS_ALWAYS0) || (clsNext == CLS_ALWAYS1);
    mergedNext = maskBits[aAddr] & stableNext;
  end

  // stage B: result registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outAddr   <= '0;
      outClass  <= 3'd0;
      outStable <= 1'b0;
      outMerged <= 1'b0;
    end else if (strobe.loadB) begin
      outAddr   <= aAddr;
      outClass  <= clsNext;
      outStable <= stableNext;
      outMerged <= mergedNext;
    end
  end

  // sticky usable mask, clear takes precedence
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      maskBits <= '1;
    else if (strobe.clearAll)
      maskBits <= '1;
    else if (strobe.loadB)
      maskBits[aAddr] <= mergedNext;
  end

  AST_CLEAR_ALL_USABLE: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.clearAll) |-> (&maskBits)); // R9
  AST_MERGED_NEEDS_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.loadB) && outMerged |-> outStable); // R8
  AST_MASK_NEVER_RISES: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.clearAll) |-> ($countones(maskBits) <= $countones($past(maskBits)))); // R8

endmodule

// File: rtl/cell_stability_classifier.sv
module cell_stability_classifier
  import cell_class_pkg::*;
#(
  parameter int ADDR_W        = 8,
  parameter int CNT_W         = 11,
  parameter int HALF_PERMILLE = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clearMask,
  input  logic              inValid,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [CNT_W-1:0]  inOnes,
  input  logic [CNT_W-1:0]  inTotal,
  output logic              outValid,
  output logic [ADDR_W-1:0] outAddr,
  output logic [2:0]        outClass,
  output logic              outStable,
  output logic              outMerged
);
  ctrlStrobe_t strobe;

  classifier_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .clearMask(clearMask),
    .strobe   (strobe),
    .outValid (outValid)
  );

  classifier_dp #(
    .ADDR_W       (ADDR_W),
    .CNT_W        (CNT_W),
    .HALF_PERMILLE(HALF_PERMILLE)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .inAddr   (inAddr),
    .inOnes   (inOnes),
    .inTotal  (inTotal),
    .outAddr  (outAddr),
    .outClass (outClass),
    .outStable(outStable),
    .outMerged(outMerged)
  );

  AST_CLASS_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outClass <= 3'd4)); // R1
  AST_ALWAYS0_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    outValid && (outClass == 3'd0) |-> ($past(inOnes, 2) == '0)); // R2
  AST_ALWAYS1_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    outValid && (outClass == 3'd4) |-> ($past(inOnes, 2) != '0) && ($past(inOnes, 2) >= $past(inTotal, 2))); // R3
  AST_ADDR_ECHO: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outAddr == $past(inAddr, 2))); // R7

endmodule

// File: tb/cell_stability_classifier_test.sv
module cell_stability_classifier_test;
  localparam int ADDR_W = 8;
  localparam int CNT_W  = 11;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              clearMask = 1'b0;
  logic              inValid = 1'b0;
  logic [ADDR_W-1:0] inAddr = '0;
  logic [CNT_W-1:0]  inOnes = '0;
  logic [CNT_W-1:0]  inTotal = '0;
  logic              outValid;
  logic [ADDR_W-1:0] outAddr;
  logic [2:0]        outClass;
  logic              outStable;
  logic              outMerged;

  int nChecks = 0;
  int nFail = 0;
  int cycles = 0;
  bit expMask [256];

  cell_stability_classifier #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rstN(rstN), .clearMask(clearMask), .inValid(inValid),
    .inAddr(inAddr), .inOnes(inOnes), .inTotal(inTotal),
    .outValid(outValid), .outAddr(outAddr), .outClass(outClass),
    .outStable(outStable), .outMerged(outMerged)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 50000) begin
      nFail = nFail + 1;
      $display("FAIL watchdog R7: got no completion, expected end before 50000 cycles");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    nChecks = nChecks + 1;
    if (got != exp) begin
      nFail = nFail + 1;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int expClass(input int ones, input int total);
    int mid, d;
    mid = total / 2;
    d = (total * 20 + 500) / 1000;
    if (ones == 0) return 0;
    if (ones >= total) return 4;
    if (ones > mid - d && ones <= mid + d) return 2;
    if (ones <= mid - d) return 1;
    return 3;
  endfunction

  task automatic checkResult(input int addr, input int ones, input int total, input string tag);
    int ec;
    bit es, em;
    ec = expClass(ones, total);
    es = (ec == 0 || ec == 4);
    em = expMask[addr] & es;
    expMask[addr] = em;
    chk({tag, " valid"}, outValid, 1);
    chk({tag, " addr"}, outAddr, addr);
    chk({tag, " class"}, outClass, ec);
    chk({tag, " R1 stable"}, outStable, es);
    chk({tag, " R8 merged"}, outMerged, em);
  endtask

  task automatic runCell(input int addr, input int ones, input int total, input string tag);
    @(negedge clk);
    inValid = 1'b1; inAddr = addr[ADDR_W-1:0];
    inOnes = ones[CNT_W-1:0]; inTotal = total[CNT_W-1:0];
    @(negedge clk);
    inValid = 1'b0;
    chk("R7 not early", outValid, 0);
    @(negedge clk);
    checkResult(addr, ones, total, tag);
  endtask

  task automatic doClear();
    @(negedge clk);
    clearMask = 1'b1;
    @(negedge clk);
    clearMask = 1'b0;
    foreach (expMask[i]) expMask[i] = 1'b1;
  endtask

  task automatic testReset();
    foreach (expMask[i]) expMask[i] = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R7 reset idle", outValid, 0);
    runCell(1, 1000, 1000, "R9 reset usable");
  endtask

  task automatic testBounds1000();
    runCell(10, 0, 1000, "R2 zero");
    runCell(11, 1, 1000, "R5 one");
    runCell(12, 480, 1000, "R5 top lean0");
    runCell(13, 481, 1000, "R4 band low");
    runCell(14, 500, 1000, "R4 band mid");
    runCell(15, 520, 1000, "R4 band high");
    runCell(16, 521, 1000, "R6 bottom lean1");
    runCell(17, 999, 1000, "R6 top lean1");
    runCell(18, 1000, 1000, "R3 full");
    runCell(19, 1005, 1000, "R3 over total");
  endtask

  task automatic testScaling();
    runCell(20, 240, 500, "R5 t500 below band");
    runCell(21, 241, 500, "R4 t500 band low");
    runCell(22, 260, 500, "R4 t500 band high");
    runCell(23, 261, 500, "R6 t500 above band");
    runCell(24, 17, 37, "R5 t37 below band");
    runCell(25, 18, 37, "R4 t37 band low");
    runCell(26, 19, 37, "R4 t37 band high");
    runCell(27, 20, 37, "R6 t37 above band");
    runCell(28, 0, 0, "R2 zero total");
  endtask

  task automatic testMerge();
    doClear();
    runCell(5, 1000, 1000, "R8 pass1 stable");
    runCell(5, 700, 1000, "R8 pass2 flaky");
    runCell(5, 0, 1000, "R8 pass3 sticky");
    runCell(6, 0, 1000, "R8 neighbour untouched");
    doClear();
    runCell(5, 0, 1000, "R9 after clear");
  endtask

  task automatic testClearWins();
    doClear();
    @(negedge clk);
    inValid = 1'b1; inAddr = 9; inOnes = 300; inTotal = 1000;
    @(negedge clk);
    inValid = 1'b0; clearMask = 1'b1;
    @(negedge clk);
    clearMask = 1'b0;
    checkResult(9, 300, 1000, "R9 clash result");
    foreach (expMask[i]) expMask[i] = 1'b1;
    runCell(9, 1000, 1000, "R9 clear wins");
  endtask

  task automatic testBurst();
    int ones [3] = '{1000, 10, 0};
    doClear();
    for (int n = 0; n < 5; n++) begin
      @(negedge clk);
      if (n >= 2) checkResult(40, ones[n-2], 1000, "R7 burst");
      if (n < 3) begin
        inValid = 1'b1; inAddr = 40; inOnes = ones[n][CNT_W-1:0]; inTotal = 1000;
      end else begin
        inValid = 1'b0;
      end
    end
    @(negedge clk);
    chk("R7 burst ends", outValid, 0);
  endtask

  initial begin
    testReset();
    testBounds1000();
    testScaling();
    testMerge();
    testClearWins();
    testBurst();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule